// File: doc/BRIEF.md
# External Interrupt Controller with Grouped Lines

This block takes 32 asynchronous external interrupt pins and turns them into interrupt requests for a downstream vectored interrupt controller. Every pin is synchronised, then compared against a trigger condition chosen per pin: low level, high level, falling edge, rising edge or both edges. A detected condition sets a sticky pending bit. Software acknowledges it by writing a one to that bit.

Pins 0 to 15 each get their own interrupt output. Pins 16 to 31 share a single combined output, and software finds the source by reading the pending and mask banks. Each output is the pending bit gated by a per-pin mask. A set of filter-control words is kept as plain storage for a filter circuit that sits outside this block.

Software reaches the block over a simple word-addressed register port. A write takes effect on the clock edge where `bus_wr_i` is high. Read data is a combinational function of `bus_addr_i`. Registers are grouped in banks of 8 pins, and consecutive banks are 4 bytes apart. Only word-aligned addresses are decoded.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Trigger code 0 sets the pending bit on every cycle the synchronised pin is 0. Code 1 does the same while the pin is 1. Code 2 sets it on a 1-to-0 change, code 3 on a 0-to-1 change, and code 4 on either change. Edge-set bits stay set until they are cleared.
- R2: Trigger codes 5, 6 and 7 never set the pending bit. Bit 3 of each 4-bit configuration field is not stored and reads as 0.
- R3: The trigger code of pin n is held in bits [(n mod 8)*4+2 : (n mod 8)*4] of the configuration word at byte offset 0xE00 + 4*(n/8).
- R4: The mask bit of pin n is bit (n mod 8) of the word at 0xF00 + 4*(n/8). A 1 blocks the pin's interrupt output and a 0 lets it through. After reset every mask bit is 1.
- R5: The pending bit of pin n is bit (n mod 8) of the word at 0xF40 + 4*(n/8). Writing 1 to it clears it and writing 0 leaves it unchanged. A detection in the same cycle as the clear wins, so a persisting level keeps the bit set.
- R6: Pending bits are set by detections whether or not the pin is masked.
- R7: For n < 16, `irq_line_o[n]` is 1 exactly when pin n is pending and unmasked.
- R8: `irq_group_o` is 1 exactly when at least one pin from 16 to 31 is pending and unmasked. It stays 1 while any such pin remains.
- R9: The four filter-control words at 0xE80 + 4*k (k = 0..3) read back the full 32-bit value last written to them. They reset to 0 and have no effect on detection.
- R10: A read of any address outside the four bank regions, or of an address that is not word-aligned, returns 0. A write to such an address changes no register.
- R11: A pin change that is stable before a rising clock edge shows up in the pending bit, and in the outputs, after the third rising edge counted from that edge, and not after the second.
- R12: While reset is held, configuration, filter and pending words read 0, mask words read 0xFF, and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous external interrupt pins |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_line_o | output | 16 | Per-pin interrupt outputs for pins 0 to 15 |
| irq_group_o | output | 1 | Combined interrupt output for pins 16 to 31 |

## Verification
The hardest case to reach is the clash between a software clear and a detection landing on the same edge. The result must differ between level types, which re-assert, and edge types, which stay cleared. The sweep reaches it on every pin under every code. It holds a level, writes the clear while the level persists, and then releases the pin. Because the bench idles the pin at 0 and code 0 means low level, the very first clear of every low-level pin already collides with a live detection. The grouped output is driven through several pins being pending at once, with one cleared at a time. This shows that the combined line only drops when the last unmasked source in the group is gone.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int TRIG_W  = 3;
    localparam int FIELD_W = 4;
    localparam int BIDX_W  = ADDR_W - 2;

    localparam logic [ADDR_W-1:0] CFG_BASE  = 12'hE00;
    localparam logic [ADDR_W-1:0] FLT_BASE  = 12'hE80;
    localparam logic [ADDR_W-1:0] MASK_BASE = 12'hF00;
    localparam logic [ADDR_W-1:0] PEND_BASE = 12'hF40;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_CFG,
        RGN_FLT,
        RGN_MASK,
        RGN_PEND
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [BIDX_W-1:0]  bank;
    } decode_t;

    // True when addr falls inside a window of nbanks words starting at base.
    function automatic logic in_window(logic [ADDR_W-1:0] addr,
                                       logic [ADDR_W-1:0] base,
                                       int nbanks);
        logic [ADDR_W-1:0] off;
        off = addr - base;
        return (addr >= base) && (int'(off) < nbanks * 4);
    endfunction

    function automatic decode_t decode_addr(logic [ADDR_W-1:0] addr, int nbanks);
        decode_t d;
        logic [ADDR_W-1:0] off;
        d.region = RGN_NONE;
        off      = '0;
        if (addr[1:0] == 2'b00) begin
            if (in_window(addr, CFG_BASE, nbanks)) begin
                d.region = RGN_CFG;
                off      = addr - CFG_BASE;
            end else if (in_window(addr, FLT_BASE, nbanks)) begin
                d.region = RGN_FLT;
                off      = addr - FLT_BASE;
            end else if (in_window(addr, MASK_BASE, nbanks)) begin
                d.region = RGN_MASK;
                off      = addr - MASK_BASE;
            end else if (in_window(addr, PEND_BASE, nbanks)) begin
                d.region = RGN_PEND;
                off      = addr - PEND_BASE;
            end
        end
        d.bank = off[ADDR_W-1:2];
        return d;
    endfunction

    // Trigger evaluation for one pin from its current and previous sample.
    function automatic logic trig_hit(logic [TRIG_W-1:0] code, logic cur, logic prev);
        logic hit;
        case (code)
            TRIG_LOW:  hit = ~cur;
            TRIG_HIGH: hit = cur;
            TRIG_FALL: hit = prev & ~cur;
            TRIG_RISE: hit = ~prev & cur;
            TRIG_BOTH: hit = prev ^ cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/eic_pin_front.sv
module eic_pin_front #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] cur_o,
    output logic [NUM_PINS-1:0] prev_o
);
    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cur_o  = sync_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/eic_detect.sv
module eic_detect
    import eic_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0][TRIG_W-1:0] trig_i,
    input  logic [NUM_PINS-1:0]             cur_i,
    input  logic [NUM_PINS-1:0]             prev_i,
    output logic [NUM_PINS-1:0]             evt_o
);
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        assign evt_o[n] = trig_hit(trig_i[n], cur_i[n], prev_i[n]);
    end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int NUM_PINS      = 32,
    parameter int PINS_PER_BANK = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               wdata_i,
    output logic [DATA_W-1:0]               rdata_o,
    input  logic [NUM_PINS-1:0]             evt_i,
    output logic [NUM_PINS-1:0][TRIG_W-1:0] trig_o,
    output logic [NUM_PINS-1:0]             mask_o,
    output logic [NUM_PINS-1:0]             pend_o
);
    localparam int NUM_BANKS = NUM_PINS / PINS_PER_BANK;

    logic [NUM_PINS-1:0][TRIG_W-1:0]  trig_q;
    logic [NUM_BANKS-1:0][DATA_W-1:0] flt_q;
    logic [NUM_PINS-1:0]              mask_q;
    logic [NUM_PINS-1:0]              pend_q;
    logic [NUM_PINS-1:0]              clr;
    decode_t                          dec;

    assign dec = decode_addr(addr_i, NUM_BANKS);

    always_comb begin
        clr = '0;
        if (wr_i && dec.region == RGN_PEND) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                if (dec.bank == BIDX_W'(n / PINS_PER_BANK))
                    clr[n] = wdata_i[n % PINS_PER_BANK];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            flt_q  <= '0;
            mask_q <= '1;
            pend_q <= '0;
        end else begin
            // a detection in the same cycle outranks a clear
            pend_q <= (pend_q & ~clr) | evt_i;
            if (wr_i) begin
                case (dec.region)
                    RGN_CFG: begin
                        for (int n = 0; n < NUM_PINS; n++) begin
                            if (dec.bank == BIDX_W'(n / PINS_PER_BANK))
                                trig_q[n] <= wdata_i[(n % PINS_PER_BANK) * FIELD_W +: TRIG_W];
                        end
                    end
                    RGN_FLT: begin
                        for (int b = 0; b < NUM_BANKS; b++) begin
                            if (dec.bank == BIDX_W'(b))
                                flt_q[b] <= wdata_i;
                        end
                    end
                    RGN_MASK: begin
                        for (int n = 0; n < NUM_PINS; n++) begin
                            if (dec.bank == BIDX_W'(n / PINS_PER_BANK))
                                mask_q[n] <= wdata_i[n % PINS_PER_BANK];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        case (dec.region)
            RGN_CFG: begin
                for (int n = 0; n < NUM_PINS; n++) begin
                    if (dec.bank == BIDX_W'(n / PINS_PER_BANK))
                        rdata_o[(n % PINS_PER_BANK) * FIELD_W +: FIELD_W] = {1'b0, trig_q[n]};
                end
            end
            RGN_FLT: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (dec.bank == BIDX_W'(b))
                        rdata_o = flt_q[b];
                end
            end
            RGN_MASK: begin
                for (int n = 0; n < NUM_PINS; n++) begin
                    if (dec.bank == BIDX_W'(n / PINS_PER_BANK))
                        rdata_o[n % PINS_PER_BANK] = mask_q[n];
                end
            end
            RGN_PEND: begin
                for (int n = 0; n < NUM_PINS; n++) begin
                    if (dec.bank == BIDX_W'(n / PINS_PER_BANK))
                        rdata_o[n % PINS_PER_BANK] = pend_q[n];
                end
            end
            default: ;
        endcase
    end

    assign trig_o = trig_q;
    assign mask_o = mask_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_PINS      = 32,
    parameter int PINS_PER_BANK = 8,
    parameter int NUM_DEDICATED = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_PINS-1:0]      pin_i,
    input  logic                     bus_wr_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [DATA_W-1:0]        bus_wdata_i,
    output logic [DATA_W-1:0]        bus_rdata_o,
    output logic [NUM_DEDICATED-1:0] irq_line_o,
    output logic                     irq_group_o
);
    logic [NUM_PINS-1:0]             cur;
    logic [NUM_PINS-1:0]             prev;
    logic [NUM_PINS-1:0]             evt;
    logic [NUM_PINS-1:0][TRIG_W-1:0] trig;
    logic [NUM_PINS-1:0]             mask;
    logic [NUM_PINS-1:0]             pend;
    logic [NUM_PINS-1:0]             live;

    eic_pin_front #(.NUM_PINS(NUM_PINS)) front_i (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    eic_detect #(.NUM_PINS(NUM_PINS)) detect_i (
        .trig_i (trig),
        .cur_i  (cur),
        .prev_i (prev),
        .evt_o  (evt)
    );

    eic_regs #(
        .NUM_PINS      (NUM_PINS),
        .PINS_PER_BANK (PINS_PER_BANK)
    ) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .evt_i   (evt),
        .trig_o  (trig),
        .mask_o  (mask),
        .pend_o  (pend)
    );

    assign live        = pend & ~mask;
    assign irq_line_o  = live[NUM_DEDICATED-1:0];
    assign irq_group_o = |live[NUM_PINS-1:NUM_DEDICATED];
endmodule

// File: rtl/eic_checker.sv
module eic_checker
    import eic_pkg::*;
#(
    parameter int NUM_PINS      = 32,
    parameter int PINS_PER_BANK = 8,
    parameter int NUM_DEDICATED = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr_i,
    input logic [ADDR_W-1:0]        bus_addr_i,
    input logic [DATA_W-1:0]        bus_wdata_i,
    input logic [DATA_W-1:0]        bus_rdata_o,
    input logic [NUM_DEDICATED-1:0] irq_line_o,
    input logic                     irq_group_o,
    input logic [NUM_PINS-1:0]      mask,
    input logic [NUM_PINS-1:0]      pend,
    input logic [NUM_PINS-1:0]      evt
);
    localparam int NUM_BANKS = NUM_PINS / PINS_PER_BANK;

    function automatic logic [DATA_W-1:0] pad_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < PINS_PER_BANK; k++) m[k * FIELD_W + TRIG_W] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] PAD = pad_bits();

    decode_t             dec;
    logic [NUM_PINS-1:0] clr_m;
    logic                past_ok_q;

    assign dec = decode_addr(bus_addr_i, NUM_BANKS);

    always_comb begin
        clr_m = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (bus_wr_i && dec.region == RGN_PEND &&
                int'(dec.bank) == n / PINS_PER_BANK)
                clr_m[n] = bus_wdata_i[n % PINS_PER_BANK];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok_q <= 1'b1;
    end

    // R5: a pending bit only drops after a write of 1 to its position
    p_clear_by_write_r5: assert property (@(posedge clk) disable iff (rst)
        past_ok_q |-> ((($past(pend) & ~pend) & ~$past(clr_m)) == '0));

    // R1: a pending bit only rises after a detection
    p_set_by_event_r1: assert property (@(posedge clk) disable iff (rst)
        past_ok_q |-> (((pend & ~$past(pend)) & ~$past(evt)) == '0));

    // R7: a masked dedicated pin never drives its line
    p_line_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_line_o & mask[NUM_DEDICATED-1:0]) == '0);

    // R8: the group line needs a pending pin in the upper range
    p_group_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq_group_o |-> (|pend[NUM_PINS-1:NUM_DEDICATED]));

    // R10: unmapped reads return zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (dec.region == RGN_NONE) |-> (bus_rdata_o == '0));

    // R2: the fourth bit of each trigger field reads zero
    p_cfg_pad_r2: assert property (@(posedge clk) disable iff (rst)
        (dec.region == RGN_CFG) |-> ((bus_rdata_o & PAD) == '0));

    // R4: first cycle after reset every pin is masked
    p_reset_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && $past(rst)) |-> (&mask));
endmodule

bind ext_irq_ctrl eic_checker #(
    .NUM_PINS      (NUM_PINS),
    .PINS_PER_BANK (PINS_PER_BANK),
    .NUM_DEDICATED (NUM_DEDICATED)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_line_o  (irq_line_o),
    .irq_group_o (irq_group_o),
    .mask        (mask),
    .pend        (pend),
    .evt         (evt)
);

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;

    localparam logic [11:0] A_CFG  = 12'hE00;
    localparam logic [11:0] A_FLT  = 12'hE80;
    localparam logic [11:0] A_MASK = 12'hF00;
    localparam logic [11:0] A_PEND = 12'hF40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pins = '0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] irq_line;
    logic        irq_group;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pins),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_line_o  (irq_line),
        .irq_group_o (irq_group)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks pending bit of pin p and the outputs against the expected state.
    task automatic pin_state(input string req, input int p, input bit exp);
        logic [31:0] d;
        bus_read(A_PEND + 12'(4 * (p / 8)), d);
        check(req, d, 32'(exp) << (p % 8));
        check(req, 32'(irq_line), (p < 16 && exp) ? (32'd1 << p) : 32'd0);
        check(req, 32'(irq_group), 32'((p >= 16) && exp));
    endtask

    initial begin
        logic [31:0] d;
        // R12: reset state read while reset is held
        idle(2);
        for (int b = 0; b < 4; b++) begin
            bus_read(A_CFG + 12'(4 * b), d);  check("R12 cfg reset", d, 32'h0);
            bus_read(A_FLT + 12'(4 * b), d);  check("R12 flt reset", d, 32'h0);
            bus_read(A_MASK + 12'(4 * b), d); check("R12 mask reset", d, 32'hFF);
            bus_read(A_PEND + 12'(4 * b), d); check("R12 pend reset", d, 32'h0);
        end
        check("R12 outputs in reset", {15'd0, irq_group, irq_line}, 32'h0);
        @(negedge clk); rst = 1'b0;

        // R4: masks still all set after reset, nothing reaches outputs
        idle(5);
        bus_read(A_MASK + 12'h8, d); check("R4 mask after reset", d, 32'hFF);
        check("R4 outputs masked", {15'd0, irq_group, irq_line}, 32'h0);

        // R3 R2: field placement and dropped fourth bit
        bus_write(A_CFG + 12'h8, 32'hFEDCBA98);
        bus_read(A_CFG + 12'h8, d); check("R3 R2 cfg readback", d, 32'h76543210);

        // R9: filter storage, full width
        for (int b = 0; b < 4; b++) bus_write(A_FLT + 12'(4 * b), 32'hA5C3_0000 ^ 32'(b * 32'h1111));
        for (int b = 0; b < 4; b++) begin
            bus_read(A_FLT + 12'(4 * b), d);
            check("R9 filter readback", d, 32'hA5C3_0000 ^ 32'(b * 32'h1111));
        end

        // disable all pins, mask all, clear pendings
        for (int b = 0; b < 4; b++) bus_write(A_CFG + 12'(4 * b), 32'h77777777);
        for (int b = 0; b < 4; b++) bus_write(A_PEND + 12'(4 * b), 32'hFF);
        for (int b = 0; b < 4; b++) begin
            bus_read(A_PEND + 12'(4 * b), d); check("R2 reserved code quiet", d, 32'h0);
        end

        // R10: unmapped reads and ignored writes
        bus_read(12'hE10, d); check("R10 read gap after cfg", d, 32'h0);
        bus_read(12'hE90, d); check("R10 read gap after flt", d, 32'h0);
        bus_read(12'hF10, d); check("R10 read gap after mask", d, 32'h0);
        bus_read(12'hF50, d); check("R10 read gap after pend", d, 32'h0);
        bus_read(12'h000, d); check("R10 read low address", d, 32'h0);
        bus_read(12'hF01, d); check("R10 read misaligned", d, 32'h0);
        bus_write(12'hE10, 32'h0);
        bus_write(12'hE01, 32'h0);
        bus_write(12'hF10, 32'h0);
        bus_write(12'hF02, 32'h0);
        bus_read(A_CFG, d);  check("R10 cfg untouched", d, 32'h77777777);
        bus_read(A_MASK, d); check("R10 mask untouched", d, 32'hFF);
        bus_read(12'hE8C, d); check("R10 flt untouched", d, 32'hA5C3_0000 ^ 32'h3333);

        // R1 R2 R3 R5 R7 R8: every pin under every code
        for (int p = 0; p < 32; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic [31:0] cfgw;
                logic [11:0] ba;
                bit lvl_lo, lvl_hi, fall, rise, both;
                ba     = 12'(4 * (p / 8));
                lvl_lo = (c == 0); lvl_hi = (c == 1); fall = (c == 2);
                rise   = (c == 3); both   = (c == 4);
                cfgw   = 32'h77777777;
                cfgw[(p % 8) * 4 +: 4] = 4'(c);
                pins = '0;
                bus_write(A_CFG + ba, cfgw);
                bus_write(A_MASK + ba, 32'hFF & ~(32'd1 << (p % 8)));
                idle(4);
                bus_write(A_PEND + ba, 32'hFF);
                idle(4);
                pin_state("R1 pin low idle", p, lvl_lo);
                @(negedge clk); pins[p] = 1'b1;
                idle(4);
                pin_state("R1 after rise", p, lvl_lo | lvl_hi | rise | both);
                bus_write(A_PEND + ba, 32'hFF);
                idle(4);
                pin_state("R5 clear while high", p, lvl_hi);
                @(negedge clk); pins[p] = 1'b0;
                idle(4);
                pin_state("R1 after fall", p, lvl_hi | lvl_lo | fall | both);
                bus_write(A_PEND + ba, 32'hFF);
                idle(4);
                pin_state("R5 clear while low", p, lvl_lo);
                bus_write(A_CFG + ba, 32'h77777777);
                bus_write(A_MASK + ba, 32'hFF);
                bus_write(A_PEND + ba, 32'hFF);
            end
        end

        // R11: latency, pin 3 rising, unmasked
        bus_write(A_CFG, 32'h77773777);
        bus_write(A_MASK, 32'hF7);
        bus_write(A_PEND, 32'hFF);
        @(negedge clk); addr = A_PEND; pins[3] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R11 not after two edges", rdata, 32'h0);
        check("R11 line not after two edges", 32'(irq_line), 32'h0);
        @(posedge clk); #1;
        check("R11 set after third edge", rdata, 32'h8);
        check("R11 line after third edge", 32'(irq_line), 32'h8);
        // R5: writing 0 leaves pending unchanged
        bus_write(A_PEND, 32'h00);
        bus_read(A_PEND, d); check("R5 zero write keeps bit", d, 32'h8);
        bus_write(A_PEND, 32'h08);
        bus_read(A_PEND, d); check("R5 one write clears bit", d, 32'h0);
        bus_write(A_CFG, 32'h77777777);
        bus_write(A_MASK, 32'hFF);
        pins = '0;
        idle(4);

        // R6: masked pin 20 still captures, group follows unmask
        bus_write(A_CFG + 12'h8, 32'h77737777);
        @(negedge clk); pins[20] = 1'b1;
        idle(5);
        bus_read(A_PEND + 12'h8, d); check("R6 masked capture", d, 32'h10);
        check("R6 group held off by mask", 32'(irq_group), 32'h0);
        bus_write(A_MASK + 12'h8, 32'hEF);
        idle(1);
        check("R6 group after unmask", 32'(irq_group), 32'h1);

        // R8: pins 17 and 30 pending together, clear one at a time
        bus_write(A_PEND + 12'h8, 32'hFF);
        bus_write(A_MASK + 12'h8, 32'hFD);
        bus_write(A_MASK + 12'hC, 32'hBF);
        bus_write(A_CFG + 12'h8, 32'h77777737);
        bus_write(A_CFG + 12'hC, 32'h73777777);
        @(negedge clk); pins[17] = 1'b1; pins[30] = 1'b1;
        idle(5);
        check("R8 group two sources", 32'(irq_group), 32'h1);
        bus_write(A_PEND + 12'h8, 32'h02);
        idle(1);
        check("R8 group one source left", 32'(irq_group), 32'h1);
        bus_write(A_PEND + 12'hC, 32'h40);
        idle(1);
        check("R8 group no source", 32'(irq_group), 32'h0);
        check("R7 dedicated lines quiet", 32'(irq_line), 32'h0);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule